// File: doc/BRIEF.md
# Per-Unit Request Queue Scheduler

This block schedules commands for a peripheral controller that serves up to sixteen units. The host enqueues a request tag together with an 8-bit attribute byte for a chosen unit. Each unit keeps its own first-in first-out queue of pending tags. The request at the head of a unit's queue is the one in progress. When a legal request reaches the head, the block marks the unit busy and pulses an issue strobe that carries the tag. Every unit can have one request in progress at the same time.

When a unit reports that its request is finished, the block holds that completion until it can retire it. Retiring clears the busy flag, sets the done flag, writes one status record, removes the request from the queue and starts the unit's next request without host help. A bitmap of busy units limits completion handling to the units that have work outstanding. At most one status record is produced per cycle. When several units are waiting, the lowest unit number is retired first. A request marked illegal is never issued. It is retired as soon as it reaches the head of its queue, with the illegal bit set in its record.

Attribute byte layout, which the status record also uses: bit 7 illegal command, bit 6 aborted, bit 5 suppress host event, bit 4 done, bit 3 busy, bits 2:0 priority.

Top module: `unit_req_sched`

## Requirements
- R1: After reset, `busy_map`, `issue_valid` and `cpl_valid` are all zero and `enq_ready` is 1.
- R2: A legal request enqueued into an empty, idle unit at clock edge E drives `issue_valid[u]` high for exactly the one cycle that follows edge E+1. The unit's tag appears in `issue_tag[u*TAG_W +: TAG_W]`, and `busy_map[u]` is set from edge E+1.
- R3: Each unit issues its requests in enqueue order. When `unit_done[u]` is sampled high at edge E, the status record appears after edge E+1 if no lower unit is waiting, and `busy_map[u]` clears at that same edge. If the queue still holds a request, that request is issued after edge E+2.
- R4: The status record gives the unit number, the tag, and the info byte {illegal, aborted, suppress, 1, 0, priority}. Bits 4 and 3 of the enqueued byte, and its bit 6, have no effect on the record.
- R5: Each unit queue holds 4 requests. While unit `enq_unit` holds 4, `enq_ready` is 0, and an enqueue attempted then is discarded without overwriting any stored request.
- R6: When several units are waiting to retire, one record is produced per cycle, in ascending unit-number order.
- R7: A request whose attribute bit 7 is set is never issued to its unit. Its record, with bits 7 and 4 set, follows the edge after the one at which it reaches the head, and the next request in that queue is then issued normally.
- R8: `unit_done[u]` has no effect while `busy_map[u]` is 0: no record is produced and the bitmap does not change.
- R9: Requests in progress on different units are independent, and `busy_map` shows all of them at once.
- R10: `cpl_irq` pulses together with `cpl_valid` unless the retired request has attribute bit 5 set, in which case it stays 0.
- R11: If `unit_abort[u]` is high in the cycle where `unit_done[u]` is accepted, bit 6 of that request's record is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| enq_valid | input | 1 | Enqueue request strobe |
| enq_unit | input | 4 | Target unit of the enqueue |
| enq_tag | input | 6 | Request tag |
| enq_info | input | 8 | Request attribute byte |
| enq_ready | output | 1 | Target unit queue has room |
| issue_valid | output | 16 | One-cycle start pulse per unit |
| issue_tag | output | 96 | Tag of the issued request, 6 bits per unit |
| unit_done | input | 16 | Per-unit completion pulse |
| unit_abort | input | 16 | Per-unit abort flag, sampled with completion |
| busy_map | output | 16 | Units with a request in progress |
| cpl_valid | output | 1 | Status record valid |
| cpl_unit | output | 4 | Unit of the retired request |
| cpl_tag | output | 6 | Tag of the retired request |
| cpl_info | output | 8 | Status info byte |
| cpl_irq | output | 1 | Host completion event |

## Verification
The bench first feeds one unit a backlog that fills its queue. This separates correct in-order chaining from a queue that accepts a fifth entry or starts the wrong tag. It then completes three units in the same cycle, which shows whether records come out in ascending order, one per cycle, and whether abort and suppress stay with the right record. An illegal request placed directly in front of a legal one shows that the illegal request is skipped for issue but still recorded. A stray completion on an idle unit shows that the busy bitmap really gates completion handling.

// File: rtl/ursched_pkg.sv
package ursched_pkg;

    localparam int INFO_W   = 8;
    localparam int B_ILL    = 7;
    localparam int B_ABT    = 6;
    localparam int B_SUP    = 5;
    localparam int B_DONE   = 4;
    localparam int B_BUSY   = 3;
    localparam int PRI_W    = 3;

    typedef logic [INFO_W-1:0] info_t;

    // attributes kept per queued request
    typedef struct packed {
        logic             ill;
        logic             sup;
        logic [PRI_W-1:0] pri;
    } req_attr_t;

    function automatic req_attr_t attr_from_info(input info_t i);
        req_attr_t a;
        a.ill = i[B_ILL];
        a.sup = i[B_SUP];
        a.pri = i[PRI_W-1:0];
        return a;
    endfunction

    function automatic info_t record_info(input req_attr_t a, input logic aborted);
        info_t r;
        r          = '0;
        r[B_ILL]   = a.ill;
        r[B_ABT]   = aborted;
        r[B_SUP]   = a.sup;
        r[B_DONE]  = 1'b1;
        r[B_BUSY]  = 1'b0;
        r[PRI_W-1:0] = a.pri;
        return r;
    endfunction

endpackage

// File: rtl/unit_queue.sv
module unit_queue
    import ursched_pkg::*;
#(
    parameter int DEPTH = 4,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             push_i,
    input  logic [TAG_W-1:0] push_tag_i,
    input  req_attr_t        push_attr_i,
    output logic             full_o,
    input  logic             done_i,
    input  logic             abort_i,
    input  logic             grant_i,
    output logic             cand_o,
    output logic [TAG_W-1:0] head_tag_o,
    output req_attr_t        head_attr_o,
    output logic             pend_abort_o,
    output logic             busy_o,
    output logic             issue_o
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [TAG_W-1:0] tag_mem  [DEPTH];
    req_attr_t        attr_mem [DEPTH];
    logic [PTR_W-1:0] rd_ptr, wr_ptr;
    logic [CNT_W-1:0] cnt;
    logic             busy, pend, pend_abt, issue_q;
    logic             push_ok, nonempty, start;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full_o      = (cnt == CNT_W'(DEPTH));
    assign push_ok     = push_i & ~full_o;
    assign nonempty    = (cnt != '0);
    assign head_tag_o  = tag_mem[rd_ptr];
    assign head_attr_o = attr_mem[rd_ptr];
    assign start       = ~busy & nonempty & ~head_attr_o.ill & ~grant_i;
    assign cand_o      = pend | (~busy & nonempty & head_attr_o.ill);

    always_ff @(posedge clk) begin
        if (push_ok) begin
            tag_mem[wr_ptr]  <= push_tag_i;
            attr_mem[wr_ptr] <= push_attr_i;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_ptr <= '0;
            wr_ptr <= '0;
            cnt    <= '0;
        end else begin
            if (push_ok)
                wr_ptr <= bump(wr_ptr);
            if (grant_i)
                rd_ptr <= bump(rd_ptr);
            case ({push_ok, grant_i})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            busy     <= 1'b0;
            pend     <= 1'b0;
            pend_abt <= 1'b0;
            issue_q  <= 1'b0;
        end else begin
            issue_q <= start;
            if (grant_i) begin
                busy     <= 1'b0;
                pend     <= 1'b0;
                pend_abt <= 1'b0;
            end else begin
                if (start)
                    busy <= 1'b1;
                if (busy & ~pend & done_i) begin
                    pend     <= 1'b1;
                    pend_abt <= abort_i;
                end
            end
        end
    end

    assign busy_o       = busy;
    assign issue_o      = issue_q;
    assign pend_abort_o = pend_abt;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt <= CNT_W'(DEPTH)); // R5
    AST_REFUSE_KEEPS: assert property (@(posedge clk) disable iff (rst)
        (push_i && full_o && !grant_i) |=> (cnt == $past(cnt))); // R5
    AST_PEND_NEEDS_BUSY: assert property (@(posedge clk) disable iff (rst)
        pend |-> busy); // R8
    AST_GRANT_RETIRES: assert property (@(posedge clk) disable iff (rst)
        grant_i |=> !busy_o); // R3
    AST_ISSUE_MARKS_BUSY: assert property (@(posedge clk) disable iff (rst)
        issue_o |-> busy_o); // R2

endmodule

// File: rtl/retire_arbiter.sv
module retire_arbiter #(
    parameter int N = 16
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [N-1:0]         cand_i,
    output logic [N-1:0]         grant_o,
    output logic [$clog2(N)-1:0] idx_o,
    output logic                 any_o
);
    localparam int IW = $clog2(N);

    // lowest set bit wins
    assign grant_o = cand_i & (~cand_i + 1'b1);
    assign any_o   = |cand_i;

    always_comb begin
        idx_o = '0;
        for (int i = 0; i < N; i++)
            if (grant_o[i])
                idx_o = IW'(i);
    end

    AST_ONE_GRANT: assert property (@(posedge clk) disable iff (rst)
        $onehot0(grant_o)); // R6
    AST_GRANT_LOWEST: assert property (@(posedge clk) disable iff (rst)
        any_o |-> ((cand_i & ((grant_o) - 1'b1)) == '0)); // R6

endmodule

// File: rtl/cpl_recorder.sv
module cpl_recorder
    import ursched_pkg::*;
#(
    parameter int UW    = 4,
    parameter int TAG_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             any_i,
    input  logic [UW-1:0]    unit_i,
    input  logic [TAG_W-1:0] tag_i,
    input  req_attr_t        attr_i,
    input  logic             abort_i,
    output logic             cpl_valid_o,
    output logic [UW-1:0]    cpl_unit_o,
    output logic [TAG_W-1:0] cpl_tag_o,
    output info_t            cpl_info_o,
    output logic             cpl_irq_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cpl_valid_o <= 1'b0;
            cpl_unit_o  <= '0;
            cpl_tag_o   <= '0;
            cpl_info_o  <= '0;
            cpl_irq_o   <= 1'b0;
        end else begin
            cpl_valid_o <= any_i;
            cpl_irq_o   <= any_i & ~attr_i.sup;
            if (any_i) begin
                cpl_unit_o <= unit_i;
                cpl_tag_o  <= tag_i;
                cpl_info_o <= record_info(attr_i, abort_i & ~attr_i.ill);
            end
        end
    end

    AST_IRQ_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
        cpl_irq_o |-> cpl_valid_o); // R10

endmodule

// File: rtl/unit_req_sched.sv
module unit_req_sched
    import ursched_pkg::*;
#(
    parameter int NUNITS = 16,
    parameter int DEPTH  = 4,
    parameter int TAG_W  = 6,
    parameter int UW     = $clog2(NUNITS)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    enq_valid,
    input  logic [UW-1:0]           enq_unit,
    input  logic [TAG_W-1:0]        enq_tag,
    input  logic [INFO_W-1:0]       enq_info,
    output logic                    enq_ready,
    output logic [NUNITS-1:0]       issue_valid,
    output logic [NUNITS*TAG_W-1:0] issue_tag,
    input  logic [NUNITS-1:0]       unit_done,
    input  logic [NUNITS-1:0]       unit_abort,
    output logic [NUNITS-1:0]       busy_map,
    output logic                    cpl_valid,
    output logic [UW-1:0]           cpl_unit,
    output logic [TAG_W-1:0]        cpl_tag,
    output logic [INFO_W-1:0]       cpl_info,
    output logic                    cpl_irq
);
    logic [NUNITS-1:0] full_v, cand_v, grant_v, pabt_v;
    logic [TAG_W-1:0]  head_tag [NUNITS];
    req_attr_t         head_attr[NUNITS];
    logic [UW-1:0]     sel_idx;
    logic              sel_any;
    req_attr_t         in_attr;

    assign in_attr   = attr_from_info(enq_info);
    assign enq_ready = ~full_v[enq_unit];

    for (genvar u = 0; u < NUNITS; u++) begin : g_unit
        unit_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W)) u_q (
            .clk          (clk),
            .rst          (rst),
            .push_i       (enq_valid && (enq_unit == UW'(u))),
            .push_tag_i   (enq_tag),
            .push_attr_i  (in_attr),
            .full_o       (full_v[u]),
            .done_i       (unit_done[u]),
            .abort_i      (unit_abort[u]),
            .grant_i      (grant_v[u]),
            .cand_o       (cand_v[u]),
            .head_tag_o   (head_tag[u]),
            .head_attr_o  (head_attr[u]),
            .pend_abort_o (pabt_v[u]),
            .busy_o       (busy_map[u]),
            .issue_o      (issue_valid[u])
        );
        assign issue_tag[u*TAG_W +: TAG_W] = head_tag[u];
    end

    retire_arbiter #(.N(NUNITS)) u_arb (
        .clk     (clk),
        .rst     (rst),
        .cand_i  (cand_v),
        .grant_o (grant_v),
        .idx_o   (sel_idx),
        .any_o   (sel_any)
    );

    cpl_recorder #(.UW(UW), .TAG_W(TAG_W)) u_rec (
        .clk         (clk),
        .rst         (rst),
        .any_i       (sel_any),
        .unit_i      (sel_idx),
        .tag_i       (head_tag[sel_idx]),
        .attr_i      (head_attr[sel_idx]),
        .abort_i     (pabt_v[sel_idx]),
        .cpl_valid_o (cpl_valid),
        .cpl_unit_o  (cpl_unit),
        .cpl_tag_o   (cpl_tag),
        .cpl_info_o  (cpl_info),
        .cpl_irq_o   (cpl_irq)
    );

    AST_CPL_FOLLOWS_GRANT: assert property (@(posedge clk) disable iff (rst)
        sel_any |=> cpl_valid); // R4
    AST_RECORD_DONE_FLAGS: assert property (@(posedge clk) disable iff (rst)
        cpl_valid |-> (cpl_info[B_DONE] && !cpl_info[B_BUSY])); // R4
    AST_ISSUE_IS_PULSE: assert property (@(posedge clk) disable iff (rst)
        (issue_valid != '0) |=> ((issue_valid & $past(issue_valid)) == '0)); // R2

endmodule

// File: tb/unit_req_sched_bench.sv
module unit_req_sched_bench;
    localparam int NU = 16;
    localparam int TW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          enq_valid = 1'b0;
    logic [3:0]    enq_unit = '0;
    logic [TW-1:0] enq_tag = '0;
    logic [7:0]    enq_info = '0;
    logic          enq_ready;
    logic [NU-1:0] issue_valid;
    logic [NU*TW-1:0] issue_tag;
    logic [NU-1:0] unit_done = '0;
    logic [NU-1:0] unit_abort = '0;
    logic [NU-1:0] busy_map;
    logic          cpl_valid, cpl_irq;
    logic [3:0]    cpl_unit;
    logic [TW-1:0] cpl_tag;
    logic [7:0]    cpl_info;

    int checks = 0;
    int errors = 0;
    logic [18:0] exp_q[$];

    always #2 clk = ~clk;

    unit_req_sched u_unit_req_sched (
        .clk(clk), .rst(rst), .enq_valid(enq_valid), .enq_unit(enq_unit),
        .enq_tag(enq_tag), .enq_info(enq_info), .enq_ready(enq_ready),
        .issue_valid(issue_valid), .issue_tag(issue_tag),
        .unit_done(unit_done), .unit_abort(unit_abort), .busy_map(busy_map),
        .cpl_valid(cpl_valid), .cpl_unit(cpl_unit), .cpl_tag(cpl_tag),
        .cpl_info(cpl_info), .cpl_irq(cpl_irq)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic report();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // scoreboard push: {irq, unit, tag, info}
    task automatic expect_rec(input int u, input int tag, input logic [7:0] info, input bit irq);
        exp_q.push_back({irq, 4'(u), 6'(tag), info});
    endtask

    task automatic enq(input int u, input int tag, input logic [7:0] info);
        @(negedge clk);
        enq_valid = 1'b1; enq_unit = 4'(u); enq_tag = 6'(tag); enq_info = info;
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic fin(input logic [NU-1:0] m, input logic [NU-1:0] ab);
        @(negedge clk);
        unit_done = m; unit_abort = ab;
        @(negedge clk);
        unit_done = '0; unit_abort = '0;
    endtask

    function automatic logic [TW-1:0] itag(input int u);
        return issue_tag[u*TW +: TW];
    endfunction

    // monitor: pops expected records as the design retires requests
    always @(negedge clk) begin
        if (!rst && cpl_valid) begin
            if (exp_q.size() == 0) begin
                chk(0, "R8", "unexpected record", {cpl_unit, cpl_tag}, 0);
            end else begin
                logic [18:0] e;
                e = exp_q.pop_front();
                chk({cpl_irq, cpl_unit, cpl_tag, cpl_info} == e, "R4 R6 R10 R11",
                    "record", {cpl_irq, cpl_unit, cpl_tag, cpl_info}, e);
            end
        end
    end

    initial begin
        repeat (60000) @(posedge clk);
        chk(0, "R1", "watchdog expired", 0, 1);
        report();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(busy_map == 0 && issue_valid == 0 && cpl_valid == 0 && enq_ready,
            "R1", "reset state", {busy_map, issue_valid}, 0);

        // R2 first issue, host bits 4 and 3 set to show they are ignored (R4)
        expect_rec(3, 5, 8'h12, 1);
        enq(3, 5, 8'h1A);
        chk(issue_valid == 0, "R2", "no issue before edge E+1", issue_valid, 0);
        @(negedge clk);
        chk(issue_valid == 16'h0008 && itag(3) == 5, "R2", "issue unit3 tag5",
            {issue_valid, itag(3)}, {16'h0008, 6'd5});
        chk(busy_map == 16'h0008, "R2", "busy bit unit3", busy_map, 16'h0008);
        @(negedge clk);
        chk(issue_valid == 0, "R2", "issue is one cycle", issue_valid, 0);

        // R5 fill unit 3
        for (int t = 6; t <= 8; t++) begin
            expect_rec(3, t, 8'h13, 1);
            enq(3, t, 8'h03);
        end
        @(negedge clk);
        enq_valid = 1'b1; enq_unit = 4'd3; enq_tag = 6'd9; enq_info = 8'h03;
        #0.1;
        chk(enq_ready == 1'b0, "R5", "full queue refuses", enq_ready, 0);
        @(negedge clk);
        enq_valid = 1'b0;

        // R3 chaining in order
        for (int t = 5; t <= 7; t++) begin
            fin(16'h0008, '0);
            @(negedge clk);
            chk(busy_map[3] == 1'b0, "R3", "busy clears at retire", busy_map[3], 0);
            @(negedge clk);
            chk(issue_valid == 16'h0008 && itag(3) == 6'(t + 1), "R3",
                "next tag issued", {issue_valid, itag(3)}, {16'h0008, 6'(t + 1)});
        end
        fin(16'h0008, '0);
        @(negedge clk);
        @(negedge clk);
        chk(issue_valid == 0 && busy_map == 0, "R5", "refused tag never stored",
            {issue_valid, busy_map}, 0);

        // R8 stray completion on idle unit
        fin(16'h0080, '0);
        @(negedge clk);
        chk(cpl_valid == 0 && busy_map == 0, "R8", "idle done ignored",
            {cpl_valid, busy_map}, 0);

        // R9 concurrent units, R6 ordering, R10 suppress, R11 abort
        enq(9, 11, 8'h01);
        enq(2, 12, 8'h24);
        enq(12, 13, 8'h07);
        @(negedge clk);
        chk(busy_map == 16'h1204, "R9", "three units busy", busy_map, 16'h1204);
        expect_rec(2, 12, 8'h34, 0);
        expect_rec(9, 11, 8'h11, 1);
        expect_rec(12, 13, 8'h57, 1);
        fin(16'h1204, 16'h1000);
        chk(busy_map == 16'h1204, "R6", "pending still busy", busy_map, 16'h1204);
        @(negedge clk);
        chk(busy_map == 16'h1200, "R6", "lowest unit retired first", busy_map, 16'h1200);
        @(negedge clk);
        chk(busy_map == 16'h1000, "R6", "second unit retired", busy_map, 16'h1000);
        @(negedge clk);
        chk(busy_map == 0, "R6", "all retired", busy_map, 0);

        // R7 illegal followed by legal on unit 5
        expect_rec(5, 20, 8'h96, 1);
        enq(5, 20, 8'h86);
        chk(issue_valid == 0, "R7", "illegal not issued", issue_valid, 0);
        enq(5, 21, 8'h02);
        chk(issue_valid == 0, "R7", "illegal not issued later", issue_valid, 0);
        @(negedge clk);
        chk(issue_valid == 16'h0020 && itag(5) == 21, "R7", "legal after illegal issued",
            {issue_valid, itag(5)}, {16'h0020, 6'd21});
        expect_rec(5, 21, 8'h12, 1);
        fin(16'h0020, '0);
        repeat (3) @(negedge clk);
        chk(exp_q.size() == 0, "R4", "all records seen", exp_q.size(), 0);
        report();
    end
endmodule